// File: doc/BRIEF.md
# Three-Channel Tone and Noise Mixer

This block produces three square-wave tone voices and one shared pseudo-random noise stream. Each voice is gated through an active-low enable mask, so every channel can carry tone, noise, both, or neither. All settings come in through a simple register-write port made of an address, a data byte and a write strobe. That port loads the three 12-bit tone periods, the 5-bit noise period, the mixer mask and a per-channel amplitude byte.

The amplitude byte is decoded into a mode bit and a 4-bit fixed level. Both are passed to the outputs for a downstream volume stage, which lies outside this block. A shared prescaler counts input clocks. The tone counters advance every 8 clocks, so a full tone period is 16·P input clocks. The noise counter advances every 16 clocks. With a 1 MHz clock, P = 239 gives a tone near 261.5 Hz.

Top module: `tri_voice_mixer`

## Requirements
- R1: After reset release the state is as follows. All six mixer enables are active (mask 0). All tone and noise periods are 0. The amplitude mode and level outputs are 0. Every tone output starts low, so chan_o reads 0.
- R2: Each tone period is 12 bits wide. The low byte is written at the fine address and the top four bits come from data bits 3:0 at the coarse address. The fine/coarse addresses are 0/1 for A, 2/3 for B and 4/5 for C. Data bits 7:4 of a coarse write are ignored.
- R3: A tone output toggles every 8·P input clocks, where P = 0 counts as 1. Counting from reset release with the period written before edge 8, the tone after edge e equals bit 0 of floor(e / (8·P)).
- R4: Noise comes from a 17-bit register seeded to 1 at reset. Each step shifts it toward bit 0 and loads bit 16 with bit0 XOR bit3. The noise output is bit 0. The register steps once every 16·N clocks, where N is data bits 4:0 at address 6 and N = 0 counts as 1. Bits 7:5 of that write are ignored.
- R5: Address 7 holds the active-low mask. Bits 0–2 disable tone on A–C and bits 3–5 disable noise on A–C. Each channel output is (tone OR tone_disable) AND (noise OR noise_disable). Bits 7:6 do not affect any channel output.
- R6: Addresses 8, 9 and 10 hold the amplitude bytes for A, B and C. Bit 4 drives that channel's amp_env_o bit and bits 3:0 drive its amp_lvl_o nibble. Bits 7:5 are ignored. The new value appears on the clock edge that samples the write.
- R7: Writes to addresses 11 through 15 change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 8 | Register write data |
| chan_o | output | 3 | Mixed channel bits, bit 0 = A |
| amp_env_o | output | 3 | Amplitude mode bit per channel, bit 0 = A |
| amp_lvl_o | output | 12 | Fixed level per channel, A in bits 3:0 |

## Verification
The hardest part to reach from the ports is a known phase relation between the free-running prescaler, the period counters and the noise register. Without it, no output bit can be predicted in a given cycle. The stimulus therefore restarts the block with a reset before every case. It then loads all eight registers in the first eight clocks after release, before the first tone tick at edge 8 and the first noise tick at edge 16. This makes every later output bit an arithmetic function of the edge count. On that basis the bench sweeps all 64 mask values, tone periods from 0 up to values that need the coarse nibble, and noise periods from 0 to 31.

// File: rtl/tvm_pkg.sv
package tvm_pkg;
  localparam int NUM_CH   = 3;
  localparam int PER_W    = 12;
  localparam int FINE_W   = 8;
  localparam int NPER_W   = 5;
  localparam int LVL_W    = 4;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 8;
  localparam int LFSR_W   = 17;
  localparam int LFSR_TAP = 3;
  localparam int TONE_DIV = 8;
  localparam int NOISE_DIV = 16;

  typedef struct packed {
    logic             env;
    logic [LVL_W-1:0] lvl;
  } amp_t;
endpackage

// File: rtl/tvm_prescale.sv
module tvm_prescale #(
  parameter int TONE_DIV  = tvm_pkg::TONE_DIV,
  parameter int NOISE_DIV = tvm_pkg::NOISE_DIV
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tone_tick_o,
  output logic noise_tick_o
);
  localparam int PRE_W = $clog2(NOISE_DIV);
  localparam int TW    = $clog2(TONE_DIV);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  assign tone_tick_o  = &pre_q[TW-1:0];
  assign noise_tick_o = &pre_q;

  // R3
  tick_nest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    noise_tick_o |-> tone_tick_o);

  // R3
  tick_space_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tone_tick_o |=> !tone_tick_o);
endmodule

// File: rtl/tvm_regs.sv
module tvm_regs
  import tvm_pkg::*;
#(
  parameter int NCH = tvm_pkg::NUM_CH,
  parameter int PW  = tvm_pkg::PER_W,
  parameter int NPW = tvm_pkg::NPER_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  output logic [NCH*PW-1:0]    tone_per_o,
  output logic [NPW-1:0]       noise_per_o,
  output logic [NCH-1:0]       tone_dis_o,
  output logic [NCH-1:0]       noise_dis_o,
  output amp_t [NCH-1:0]       amp_o
);
  localparam int CRS_W     = PW - FINE_W;
  localparam int NOISE_ADR = 2 * NCH;
  localparam int MIX_ADR   = NOISE_ADR + 1;
  localparam int AMP_BASE  = MIX_ADR + 1;
  localparam int LAST_ADR  = AMP_BASE + NCH - 1;

  logic [NPW-1:0]   nper_q;
  logic [2*NCH-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nper_q <= '0;
      mask_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_W'(NOISE_ADR)) nper_q <= wr_data_i[NPW-1:0];
      if (wr_addr_i == ADDR_W'(MIX_ADR))   mask_q <= wr_data_i[2*NCH-1:0];
    end
  end

  assign noise_per_o = nper_q;
  assign tone_dis_o  = mask_q[NCH-1:0];
  assign noise_dis_o = mask_q[2*NCH-1:NCH];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [FINE_W-1:0] fine_q;
    logic [CRS_W-1:0]  crs_q;
    amp_t              amp_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        fine_q <= '0;
        crs_q  <= '0;
        amp_q  <= '0;
      end else if (wr_en_i) begin
        if (wr_addr_i == ADDR_W'(2*ch))       fine_q <= wr_data_i[FINE_W-1:0];
        if (wr_addr_i == ADDR_W'(2*ch + 1))   crs_q  <= wr_data_i[CRS_W-1:0];
        if (wr_addr_i == ADDR_W'(AMP_BASE + ch))
          amp_q <= wr_data_i[LVL_W:0];
      end
    end

    assign tone_per_o[ch*PW +: PW] = {crs_q, fine_q};
    assign amp_o[ch] = amp_q;

    // R6
    amp_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && wr_addr_i == ADDR_W'(AMP_BASE + ch)
      |=> amp_o[ch].env == $past(wr_data_i[LVL_W]) &&
          amp_o[ch].lvl == $past(wr_data_i[LVL_W-1:0]));
  end

  // R7
  bad_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i > ADDR_W'(LAST_ADR)
    |=> $stable(mask_q) && $stable(nper_q) && $stable(amp_o) && $stable(tone_per_o));
endmodule

// File: rtl/tvm_tone.sv
module tvm_tone #(
  parameter int PW = tvm_pkg::PER_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [PW-1:0] per_i,
  output logic          tone_o
);
  logic [PW-1:0] cnt_q, lim;
  logic          tone_q;

  // zero period runs as period 1
  assign lim = (per_i == '0) ? '0 : per_i - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tone_q <= 1'b0;
    end else if (tick_i) begin
      if (cnt_q >= lim) begin
        cnt_q  <= '0;
        tone_q <= ~tone_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign tone_o = tone_q;

  // R3
  tone_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(tone_q));

  // R3
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && cnt_q >= lim |=> cnt_q == '0 && tone_q != $past(tone_q));
endmodule

// File: rtl/tvm_noise.sv
module tvm_noise #(
  parameter int NPW = tvm_pkg::NPER_W,
  parameter int LW  = tvm_pkg::LFSR_W,
  parameter int TAP = tvm_pkg::LFSR_TAP
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic [NPW-1:0] per_i,
  output logic           bit_o
);
  logic [NPW-1:0] cnt_q, lim;
  logic [LW-1:0]  lfsr_q;
  logic           step;

  assign lim  = (per_i == '0) ? '0 : per_i - 1'b1;
  assign step = tick_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lfsr_q <= LW'(1);
    end else if (tick_i) begin
      if (step) begin
        cnt_q  <= '0;
        lfsr_q <= {lfsr_q[0] ^ lfsr_q[TAP], lfsr_q[LW-1:1]};
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign bit_o = lfsr_q[0];

  // R4
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);

  // R4
  lfsr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(lfsr_q));
endmodule

// File: rtl/tri_voice_mixer.sv
module tri_voice_mixer
  import tvm_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  output logic [NUM_CH-1:0]      chan_o,
  output logic [NUM_CH-1:0]      amp_env_o,
  output logic [NUM_CH*LVL_W-1:0] amp_lvl_o
);
  logic [NUM_CH*PER_W-1:0] tone_per;
  logic [NPER_W-1:0]       noise_per;
  logic [NUM_CH-1:0]       tone_dis, noise_dis, tone;
  amp_t [NUM_CH-1:0]       amp;
  logic                    tone_tick, noise_tick, noise_bit;

  tvm_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .tone_per_o (tone_per),
    .noise_per_o(noise_per),
    .tone_dis_o (tone_dis),
    .noise_dis_o(noise_dis),
    .amp_o      (amp)
  );

  tvm_prescale u_pre (
    .clk_i, .rst_ni,
    .tone_tick_o (tone_tick),
    .noise_tick_o(noise_tick)
  );

  tvm_noise u_noise (
    .clk_i, .rst_ni,
    .tick_i(noise_tick),
    .per_i (noise_per),
    .bit_o (noise_bit)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_voice
    tvm_tone u_tone (
      .clk_i, .rst_ni,
      .tick_i(tone_tick),
      .per_i (tone_per[ch*PER_W +: PER_W]),
      .tone_o(tone[ch])
    );

    assign chan_o[ch] = (tone[ch] | tone_dis[ch]) & (noise_bit | noise_dis[ch]);
    assign amp_env_o[ch] = amp[ch].env;
    assign amp_lvl_o[ch*LVL_W +: LVL_W] = amp[ch].lvl;

    // R5
    mute_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && wr_addr_i == ADDR_W'(2*NUM_CH + 1) &&
      wr_data_i[ch] && wr_data_i[NUM_CH + ch] |=> chan_o[ch]);
  end
endmodule

// File: tb/sim_tri_voice_mixer.sv
module sim_tri_voice_mixer;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [2:0]  chan, amp_env;
  logic [11:0] amp_lvl;

  int n_chk = 0;
  int n_err = 0;
  logic [4:0] amp_m [3];

  tri_voice_mixer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .chan_o(chan), .amp_env_o(amp_env), .amp_lvl_o(amp_lvl)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [16:0] nstep(input logic [16:0] v);
    return {v[0] ^ v[3], v[16:1]};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    wr_en  = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // restart, load all registers during edges 1..8, then compare every cycle
  task automatic run_case(input string req, input logic [7:0] mask,
                          input int pa, input int pb, input int pc,
                          input int np, input int ncyc);
    int per[3];
    logic [16:0] m;
    int neff;
    per[0] = pa; per[1] = pb; per[2] = pc;
    neff = (np % 32 == 0) ? 1 : np % 32;
    m = 17'd1;
    do_reset();
    for (int e = 1; e <= ncyc; e++) begin
      wr_en = (e <= 8);
      case (e)
        1: begin wr_addr = 4'd0; wr_data = 8'(pa); end
        2: begin wr_addr = 4'd1; wr_data = 8'hF0 | 8'(pa >> 8); end
        3: begin wr_addr = 4'd2; wr_data = 8'(pb); end
        4: begin wr_addr = 4'd3; wr_data = 8'hA0 | 8'(pb >> 8); end
        5: begin wr_addr = 4'd4; wr_data = 8'(pc); end
        6: begin wr_addr = 4'd5; wr_data = 8'h50 | 8'(pc >> 8); end
        7: begin wr_addr = 4'd6; wr_data = 8'hE0 | 8'(np); end
        8: begin wr_addr = 4'd7; wr_data = mask; end
        default: ;
      endcase
      @(posedge clk);
      @(negedge clk);
      if (e % (16 * neff) == 0) m = nstep(m);
      if (e >= 9) begin
        logic [2:0] expv;
        for (int c = 0; c < 3; c++) begin
          int pe;
          logic t;
          pe = (per[c] == 0) ? 1 : per[c];
          t = 1'((e / (8 * pe)) % 2);
          expv[c] = (t | mask[c]) & (m[0] | mask[3 + c]);
        end
        check(req, int'(chan), int'(expv));
      end
    end
    wr_en = 1'b0;
  endtask

  initial begin : watchdog
    #1000000;
    n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    do_reset();
    @(negedge clk);
    // R1 reset state: tone low, so mixed output 0; amplitude cleared
    check("R1 chan", int'(chan), 0);
    check("R1 env", int'(amp_env), 0);
    check("R1 lvl", int'(amp_lvl), 0);

    // R5 all 64 mask values, short periods, zero noise period
    for (int mk = 0; mk < 64; mk++)
      run_case("R5 mask sweep", 8'(mk), 1, 2, 3, 0, 150);
    // R5 top two mask bits have no effect
    run_case("R5 bits 7:6", 8'hC0, 2, 3, 1, 0, 300);
    run_case("R5 bits 7:6", 8'hFF, 2, 3, 1, 0, 300);

    // R3 R2 tone-only runs, coarse nibble in use, upper nibble ignored
    run_case("R3 tone 0/5/239", 8'h38, 0, 5, 239, 0, 8000);
    run_case("R2 tone coarse", 8'h38, 12'h123, 7, 12'h101, 0, 10000);
    run_case("R3 tone 4095 start", 8'h38, 4095, 4, 1, 0, 3000);

    // R4 noise-only runs, zero period included, upper bits of period ignored
    run_case("R4 noise N=0", 8'h07, 1, 1, 1, 0, 3000);
    run_case("R4 noise N=1", 8'h07, 1, 1, 1, 1, 1000);
    run_case("R4 noise N=2", 8'h07, 1, 1, 1, 2, 2000);
    run_case("R4 noise N=5", 8'h07, 1, 1, 1, 5, 3000);
    run_case("R4 noise N=31", 8'h07, 1, 1, 1, 31, 8000);

    // R6 amplitude sweep over every byte value, R7 ignored addresses
    do_reset();
    for (int c = 0; c < 3; c++) amp_m[c] = '0;
    for (int v = 0; v < 768; v++) begin
      int c;
      c = v % 3;
      wr_en = 1'b1;
      wr_addr = 4'(8 + c);
      wr_data = 8'(v / 3);
      amp_m[c] = 5'(v / 3);
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      for (int k = 0; k < 3; k++) begin
        check("R6 env", int'(amp_env[k]), int'(amp_m[k][4]));
        check("R6 lvl", int'(amp_lvl[k*4 +: 4]), int'(amp_m[k][3:0]));
      end
    end
    for (int a = 11; a < 16; a++) begin
      wr_en = 1'b1;
      wr_addr = 4'(a);
      wr_data = 8'hFF;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      for (int k = 0; k < 3; k++) begin
        check("R7 env", int'(amp_env[k]), int'(amp_m[k][4]));
        check("R7 lvl", int'(amp_lvl[k*4 +: 4]), int'(amp_m[k][3:0]));
      end
    end
    // R7 writes to 11..15 during an otherwise clean run leave outputs unchanged
    do_reset();
    for (int a = 11; a < 16; a++) begin
      wr_en = 1'b1;
      wr_addr = 4'(a);
      wr_data = 8'hFF;
      @(posedge clk);
      @(negedge clk);
    end
    wr_en = 1'b0;
    // edge 5 done: tone still low, mask still 0, so output 0
    check("R7 chan", int'(chan), 0);
    check("R7 env", int'(amp_env), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule